// File: doc/BRIEF.md
# RTC Status Register and Write Gate

This block holds the volatile status byte of a serial-bus real-time-clock device and decides, for every data byte a bus master tries to write, whether the write is taken or refused. It sits behind an already-decoded bus slave: the protocol engine hands it byte-level read and write strobes with an address and a space select (register space or memory array), and it answers with the status byte on reads and with a combinational accept/refuse flag that the engine turns into the acknowledge bit of the same data byte.

The status byte carries a backup-supply indicator, two alarm flags, two write-enable latches and a clock-fail flag. Alarm flags are set by match pulses from the timekeeping logic and are cleared at the end of a status read, but only the flags that were already set when that read began; an alarm that fires during the read survives it. Writes to the clock and control registers need both latches, and writes to the memory array need the first latch and an address outside the range chosen by a 3-bit protect code.

Top module: `rtc_stat_gate`

## Requirements
- R1: A read with `reg_space_i`=1 and `addr_i`=0x003F returns the status byte: bit 7 backup supply, bit 6 alarm 1 flag, bit 5 alarm 0 flag, bit 2 second enable latch, bit 1 first enable latch, bit 0 clock-fail flag, bits 4 and 3 always 0; every other address reads 0.
- R2: While `rst_n` is low at a clock edge, both enable latches and both alarm flags clear and the clock-fail flag takes the value of `pwr_lost_i`.
- R3: A pulse on `alarm_hit_i[k]` sets alarm flag k at the next clock edge.
- R4: A status read opens with `rd_start_i` (status address selected) and closes with `rd_last_i`; at the close exactly the alarm flags that were set at the opening clear, and a flag set during the read stays set.
- R5: A status-byte write of 0x02 is accepted and sets the first latch while clearing the second; 0x00 is accepted and clears both; 0x06 is accepted and sets the second latch only while the first is 1; any other value is refused and leaves both latches unchanged.
- R6: A write in register space to any address other than 0x003F is accepted only when both latches are 1.
- R7: An array write (`reg_space_i`=0, address `addr_i[14:0]`) is accepted only when the first latch is 1 and the address is not protected by `bp_i`: 000 none, 001 0x6000-0x7FFF, 010 0x4000-0x7FFF, 011 all, 100 0x0000-0x007F, 101 0x0000-0x00FF, 110 0x0000-0x01FF, 111 0x0000-0x03FF.
- R8: An accepted write to a clock register (register space 0x0030 to 0x0037) clears the clock-fail flag at that clock edge; a refused one leaves it set.
- R9: `wr_ok_o` is a combinational function of the present address, space, write data, latches and protect code, valid in the cycle the byte is presented.
- R10: Status bit 7 follows `on_backup_i` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pwr_lost_i | input | 1 | Both supplies were lost before this power-up |
| on_backup_i | input | 1 | Device is running from the backup supply |
| alarm_hit_i | input | 2 | One-cycle alarm match pulses, bit k for alarm k |
| bp_i | input | 3 | Array protect code from nonvolatile storage |
| reg_space_i | input | 1 | 1 selects register space, 0 the memory array |
| addr_i | input | 16 | Byte address of the current access |
| wr_i | input | 1 | Data-byte write strobe |
| wdata_i | input | 8 | Write data byte |
| rd_start_i | input | 1 | First cycle of a read of the addressed byte |
| rd_last_i | input | 1 | Last data bit of the current read has been sent |
| rd_data_o | output | 8 | Read data for the addressed byte |
| wr_ok_o | output | 1 | 1 accepts the presented write byte, 0 refuses it |

## Verification
A wrong latch value shows at the ports within the same cycle as the next write, because the accept flag of a clock, control or array byte depends directly on it, and on the next status read through bits 1 and 2. A lost alarm snapshot shows only at the close of a read, as a flag that survives when it should clear or clears when it arrived mid-read, so the bench injects alarms both before and between the read strobes. Protection decode errors appear immediately as an accept flag on a boundary address, which the bench probes on both sides of every range edge for all eight codes.

// File: rtl/rtc_stat_pkg.sv
// Shared constants and types for the RTC status register and write gate.
// Bit positions are those software decodes from the status byte.
package rtc_stat_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned N_ALARM = 2;

    localparam int unsigned BIT_BAT  = 7;
    localparam int unsigned BIT_AL1  = 6;
    localparam int unsigned BIT_AL0  = 5;
    localparam int unsigned BIT_RWEL = 2;
    localparam int unsigned BIT_WEL  = 1;
    localparam int unsigned BIT_FAIL = 0;

    localparam logic [DATA_W-1:0] CODE_CLR  = 8'h00;
    localparam logic [DATA_W-1:0] CODE_WEL  = 8'h02;
    localparam logic [DATA_W-1:0] CODE_RWEL = 8'h06;

    typedef enum logic [1:0] {
        TGT_STAT,
        TGT_CLK,
        TGT_CTRL,
        TGT_ARR
    } tgt_e;
endpackage

// File: rtl/rsg_target_dec.sv
// Classifies the current access as status byte, clock register,
// control register or memory array.
// Assumes the clock registers form one contiguous range in register space.
module rsg_target_dec
    import rtc_stat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned STAT_ADDR = 16'h003F,
    parameter int unsigned CLK_BASE  = 16'h0030,
    parameter int unsigned CLK_CNT   = 8
) (
    input  logic              reg_space_i,
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] CLK_LO = ADDR_W'(CLK_BASE);
    localparam logic [ADDR_W-1:0] CLK_HI = ADDR_W'(CLK_BASE + CLK_CNT);

    // Pick the target class from space select and address.
    always_comb begin
        if (!reg_space_i)
            tgt_o = TGT_ARR;
        else if (addr_i == STAT_A)
            tgt_o = TGT_STAT;
        else if (addr_i >= CLK_LO && addr_i < CLK_HI)
            tgt_o = TGT_CLK;
        else
            tgt_o = TGT_CTRL;
    end
endmodule

// File: rtl/rsg_protect.sv
// Decodes the 3-bit protect code into a protected/unprotected verdict
// for one array byte address. Upper codes protect a top fraction of the
// array, lower-page codes protect 1, 2, 4 or 8 pages from address zero.
// Assumes the array size is a power of two of at least 4 pages of 8.
module rsg_protect #(
    parameter int unsigned ARR_AW = 15,
    parameter int unsigned PAGE_B = 128
) (
    input  logic [ARR_AW-1:0] addr_i,
    input  logic [2:0]        code_i,
    output logic              prot_o
);
    localparam logic [ARR_AW:0] PAGE_W = (ARR_AW+1)'(PAGE_B);

    logic [ARR_AW:0] low_lim;

    // Limit of the protected low range: PAGE_B shifted by code[1:0].
    always_comb low_lim = PAGE_W << code_i[1:0];

    // Map code and address to the protect verdict.
    always_comb begin
        unique case (code_i)
            3'b000:  prot_o = 1'b0;
            3'b001:  prot_o = &addr_i[ARR_AW-1 -: 2];
            3'b010:  prot_o = addr_i[ARR_AW-1];
            3'b011:  prot_o = 1'b1;
            default: prot_o = ({1'b0, addr_i} < low_lim);
        endcase
    end
endmodule

// File: rtl/rsg_wr_latch.sv
// The two volatile write-enable latches and the acceptance rule for
// writes to the status byte. Only three byte values are legal; the
// second latch can only be raised on top of the first.
module rsg_wr_latch
    import rtc_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              stat_ok_o,
    output logic              wel_o,
    output logic              rwel_o
);
    logic wel_q, rwel_q;

    // Decide whether a status-byte value is acceptable right now.
    always_comb
        stat_ok_o = (wdata_i == CODE_CLR) || (wdata_i == CODE_WEL) ||
                    ((wdata_i == CODE_RWEL) && wel_q);

    // Update the latches on an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
        end else if (stat_wr_i && stat_ok_o) begin
            if (wdata_i == CODE_CLR) begin
                wel_q  <= 1'b0;
                rwel_q <= 1'b0;
            end else if (wdata_i == CODE_WEL) begin
                wel_q  <= 1'b1;
                rwel_q <= 1'b0;
            end else begin
                rwel_q <= 1'b1;
            end
        end
    end

    assign wel_o  = wel_q;
    assign rwel_o = rwel_q;
endmodule

// File: rtl/rsg_alarm_flags.sv
// Sticky alarm flags with snapshot-based clear-on-read: the flags set at
// the opening of a status read are remembered and only those are
// cleared at its close. A match in the closing cycle wins over the clear.
module rsg_alarm_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit_i,
    input  logic         rd_open_i,
    input  logic         rd_close_i,
    output logic [N-1:0] flag_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        logic flag_q, snap_q;

        // Remember the flag at read opening, forget it at read close.
        always_ff @(posedge clk) begin
            if (!rst_n)
                snap_q <= 1'b0;
            else if (rd_open_i)
                snap_q <= flag_q;
            else if (rd_close_i)
                snap_q <= 1'b0;
        end

        // Set on a match, clear at read close if captured at the opening.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else
                flag_q <= hit_i[k] | (flag_q & ~(rd_close_i & snap_q));
        end

        assign flag_o[k] = flag_q;
    end
endmodule

// File: rtl/rtc_stat_gate.sv
// Top of the RTC status register and write gate. Assembles the status
// byte, holds the clock-fail flag and forms the accept flag for every
// presented write byte. Assumes an upstream decoded bus slave that
// presents address, space and data with one-cycle strobes.
module rtc_stat_gate
    import rtc_stat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned ARR_AW    = 15,
    parameter int unsigned PAGE_B    = 128,
    parameter int unsigned STAT_ADDR = 16'h003F,
    parameter int unsigned CLK_BASE  = 16'h0030,
    parameter int unsigned CLK_CNT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_lost_i,
    input  logic               on_backup_i,
    input  logic [N_ALARM-1:0] alarm_hit_i,
    input  logic [2:0]         bp_i,
    input  logic               reg_space_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               rd_start_i,
    input  logic               rd_last_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               wr_ok_o
);
    tgt_e               tgt;
    logic               prot;
    logic               stat_ok;
    logic               wel, rwel;
    logic [N_ALARM-1:0] al_flags;
    logic               fail_q;
    logic [DATA_W-1:0]  stat_byte;

    rsg_target_dec #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .CLK_BASE (CLK_BASE),
        .CLK_CNT  (CLK_CNT)
    ) u_dec (
        .reg_space_i(reg_space_i),
        .addr_i     (addr_i),
        .tgt_o      (tgt)
    );

    rsg_protect #(
        .ARR_AW(ARR_AW),
        .PAGE_B(PAGE_B)
    ) u_prot (
        .addr_i(addr_i[ARR_AW-1:0]),
        .code_i(bp_i),
        .prot_o(prot)
    );

    rsg_wr_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr_i(wr_i && (tgt == TGT_STAT)),
        .wdata_i  (wdata_i),
        .stat_ok_o(stat_ok),
        .wel_o    (wel),
        .rwel_o   (rwel)
    );

    rsg_alarm_flags #(
        .N(N_ALARM)
    ) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (alarm_hit_i),
        .rd_open_i (rd_start_i && (tgt == TGT_STAT)),
        .rd_close_i(rd_last_i),
        .flag_o    (al_flags)
    );

    // Accept flag per target class.
    always_comb begin
        unique case (tgt)
            TGT_STAT: wr_ok_o = stat_ok;
            TGT_CLK,
            TGT_CTRL: wr_ok_o = wel && rwel;
            default:  wr_ok_o = wel && !prot;
        endcase
    end

    // Clock-fail flag: loaded at reset, cleared by an accepted clock write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_q <= pwr_lost_i;
        else if (wr_i && wr_ok_o && (tgt == TGT_CLK))
            fail_q <= 1'b0;
    end

    // Assemble the status byte; unused positions stay zero.
    always_comb begin
        stat_byte           = '0;
        stat_byte[BIT_BAT]  = on_backup_i;
        stat_byte[BIT_AL1]  = al_flags[1];
        stat_byte[BIT_AL0]  = al_flags[0];
        stat_byte[BIT_RWEL] = rwel;
        stat_byte[BIT_WEL]  = wel;
        stat_byte[BIT_FAIL] = fail_q;
    end

    // Only the status address returns data from this block.
    always_comb rd_data_o = (tgt == TGT_STAT) ? stat_byte : '0;
endmodule

// File: rtl/rsg_checker.sv
// Property checker for rtc_stat_gate, attached by bind below.
module rsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_space_i,
    input logic [15:0] addr_i,
    input logic       wr_i,
    input logic [7:0] wdata_i,
    input logic [2:0] bp_i,
    input logic [1:0] alarm_hit_i,
    input logic [7:0] rd_data_o,
    input logic       wr_ok_o,
    input logic       wel,
    input logic       rwel,
    input logic [1:0] al_flags
);
    // R1
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[4:3] == 2'b00);

    // R2
    latches_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!wel && !rwel && al_flags == 2'b00));

    // R3
    alarm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit_i[0] |=> al_flags[0]);

    // R5
    second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);

    // R5
    early_rwel_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && reg_space_i && addr_i == 16'h003F && wdata_i == 8'h06 && !wel)
        |-> !wr_ok_o);

    // R6
    reg_write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_space_i && addr_i != 16'h003F && !(wel && rwel)) |-> !wr_ok_o);

    // R7
    array_write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_space_i && (!wel || bp_i == 3'b011)) |-> !wr_ok_o);
endmodule

bind rtc_stat_gate rsg_checker u_rsg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_space_i(reg_space_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .bp_i       (bp_i),
    .alarm_hit_i(alarm_hit_i),
    .rd_data_o  (rd_data_o),
    .wr_ok_o    (wr_ok_o),
    .wel        (wel),
    .rwel       (rwel),
    .al_flags   (al_flags)
);

// File: tb/test_rtc_stat_gate.sv
// Directed bench for rtc_stat_gate: one task per scenario.
module test_rtc_stat_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_lost_i = 1'b1;
    logic        on_backup_i = 1'b0;
    logic [1:0]  alarm_hit_i = '0;
    logic [2:0]  bp_i = '0;
    logic        reg_space_i = 1'b1;
    logic [15:0] addr_i = '0;
    logic        wr_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic        rd_start_i = 1'b0;
    logic        rd_last_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        wr_ok_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    rtc_stat_gate i_rtc_stat_gate (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Read the status byte combinationally away from the edge.
    task automatic read_stat(input string req, input logic [7:0] exp);
        @(negedge clk);
        reg_space_i = 1'b1; addr_i = 16'h003F;
        #1 check(req, rd_data_o, exp);
    endtask

    // Present one write byte, check the accept flag in the same cycle.
    task automatic write_byte(input string req, input logic rs, input logic [15:0] a,
                              input logic [7:0] d, input logic exp_ok);
        @(negedge clk);
        reg_space_i = rs; addr_i = a; wdata_i = d; wr_i = 1'b1;
        #1 check(req, {7'b0, wr_ok_o}, {7'b0, exp_ok});
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic do_reset(input logic lost);
        @(negedge clk);
        rst_n = 1'b0; pwr_lost_i = lost;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic prot_model(input logic [2:0] c, input logic [14:0] a);
        case (c)
            3'd0: return 1'b0;
            3'd1: return a >= 15'h6000;
            3'd2: return a >= 15'h4000;
            3'd3: return 1'b1;
            3'd4: return a <= 15'h007F;
            3'd5: return a <= 15'h00FF;
            3'd6: return a <= 15'h01FF;
            default: return a <= 15'h03FF;
        endcase
    endfunction

    task automatic t_reset_state();
        do_reset(1'b1);
        read_stat("R2 fail flag set after total loss", 8'h01);
        @(negedge clk);
        reg_space_i = 1'b1; addr_i = 16'h0010;
        #1 check("R1 other address reads zero", rd_data_o, 8'h00);
        @(negedge clk);
        on_backup_i = 1'b1;
        addr_i = 16'h003F;
        #1 check("R10 backup bit follows input", rd_data_o, 8'h81);
        on_backup_i = 1'b0;
    endtask

    task automatic t_enable_sequence();
        write_byte("R5 0x06 refused without first latch", 1'b1, 16'h003F, 8'h06, 1'b0);
        read_stat("R5 latches unchanged", 8'h01);
        write_byte("R6 clock write refused", 1'b1, 16'h0030, 8'h12, 1'b0);
        write_byte("R7 array write refused, no latch", 1'b0, 16'h1000, 8'hAA, 1'b0);
        read_stat("R8 fail flag kept after refused write", 8'h01);
        write_byte("R5 0x02 accepted", 1'b1, 16'h003F, 8'h02, 1'b1);
        read_stat("R5 first latch set", 8'h03);
        write_byte("R6 clock write refused, one latch", 1'b1, 16'h0031, 8'h12, 1'b0);
        write_byte("R7 array write accepted", 1'b0, 16'h1000, 8'hAA, 1'b1);
        write_byte("R5 0x06 accepted", 1'b1, 16'h003F, 8'h06, 1'b1);
        read_stat("R5 second latch set", 8'h07);
        write_byte("R5 0x04 refused", 1'b1, 16'h003F, 8'h04, 1'b0);
        write_byte("R5 0x03 refused", 1'b1, 16'h003F, 8'h03, 1'b0);
        read_stat("R5 latches unchanged after bad value", 8'h07);
        write_byte("R6 control write accepted", 1'b1, 16'h0010, 8'h55, 1'b1);
        read_stat("R8 control write keeps fail flag", 8'h07);
        write_byte("R6 clock write accepted", 1'b1, 16'h0037, 8'h12, 1'b1);
        read_stat("R8 fail flag cleared", 8'h06);
    endtask

    task automatic t_protect();
        logic [14:0] probe [14] = '{15'h0000, 15'h007F, 15'h0080, 15'h00FF, 15'h0100,
                                   15'h01FF, 15'h0200, 15'h03FF, 15'h0400, 15'h3FFF,
                                   15'h4000, 15'h5FFF, 15'h6000, 15'h7FFF};
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                bp_i = 3'(c); reg_space_i = 1'b0; addr_i = {1'b0, probe[i]};
                #1 check($sformatf("R7 R9 code %0d addr %04h", c, probe[i]),
                         {7'b0, wr_ok_o}, {7'b0, ~prot_model(3'(c), probe[i])});
            end
        end
        bp_i = 3'd0;
    endtask

    task automatic t_alarms();
        @(negedge clk);
        alarm_hit_i = 2'b01;
        @(negedge clk);
        alarm_hit_i = 2'b00;
        read_stat("R3 alarm 0 flag set", 8'h26);
        @(negedge clk);
        rd_start_i = 1'b1;
        @(negedge clk);
        rd_start_i = 1'b0; alarm_hit_i = 2'b10;
        @(negedge clk);
        alarm_hit_i = 2'b00; rd_last_i = 1'b1;
        @(negedge clk);
        rd_last_i = 1'b0;
        read_stat("R4 only snapshot flag cleared", 8'h46);
        @(negedge clk);
        rd_start_i = 1'b1;
        @(negedge clk);
        rd_start_i = 1'b0; rd_last_i = 1'b1;
        @(negedge clk);
        rd_last_i = 1'b0;
        read_stat("R4 second read clears alarm 1", 8'h06);
        @(negedge clk);
        alarm_hit_i = 2'b01;
        @(negedge clk);
        alarm_hit_i = 2'b00;
    endtask

    task automatic t_clear_and_reset();
        write_byte("R5 0x00 accepted", 1'b1, 16'h003F, 8'h00, 1'b1);
        read_stat("R5 both latches cleared", 8'h20);
        write_byte("R7 array refused after clear", 1'b0, 16'h7000, 8'h11, 1'b0);
        do_reset(1'b0);
        read_stat("R2 reset without total loss", 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        t_enable_sequence();
        t_protect();
        t_alarms();
        t_clear_and_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule